// File: doc/BRIEF.md
# Cache Line-Fill Read Assembler

This block sits on the read-data side of a data cache's system-bus port. After the bus request has been issued elsewhere, a one-cycle request pulse tells the assembler what comes back: a single word or an eight-word line, and whether the answering slave drives 32 or 64 bits per transfer. The assembler then counts the read acknowledges for that transfer, picks the right half (or both halves) of the 64-bit read bus on each acknowledged beat, and files the data by the beat's word address.

A single-word read finishes after one acknowledged beat. It leaves a 32-bit word on `word_out` in which only the enabled bytes are kept. A line read fills a 256-bit buffer. It takes eight beats from a narrow slave and four beats from a wide slave, and the beats may arrive in any order with any number of idle cycles between them. A one-cycle `done` pulse marks completion. An acknowledge that arrives when no transfer is open raises a one-cycle error pulse and is otherwise discarded.

Top module: `line_fill_asm`

## Requirements
- R1: After reset `done` and `err_idle_ack` are 0, `word_out` and `line_out` are all zero, and no transfer is open.
- R2: A `req_valid` pulse while no transfer is open starts a transfer and captures `req_line` (1 = eight-word line, 0 = single word), `req_wide` (1 = 64-bit slave, 0 = 32-bit slave) and `req_be`.
- R3: A single-word read completes on its first acknowledged beat, whatever the slave width. The word is taken from `rd_data[63:32]` when `rd_waddr[0]` is 0 and from `rd_data[31:0]` when it is 1. `line_out` is left unchanged.
- R4: For a single-word read, byte k of `word_out` (bits 8k+7:8k) holds the selected byte when `req_be[k]` is 1 and is zero otherwise.
- R5: A line read from a 32-bit slave takes eight acknowledged beats. Each beat writes line word `rd_waddr`, taken from the upper bus half for an even address and from the lower half for an odd address.
- R6: A line read from a 64-bit slave takes four acknowledged beats. `rd_waddr[0]` is ignored. The upper half goes to word index {rd_waddr[2:1],0} and the lower half goes to the next index.
- R7: Line word i appears on `line_out[32i+31:32i]`.
- R8: `done` is high for exactly the one cycle after the clock edge that captures the final beat. Any number of idle cycles may separate beats.
- R9: An acknowledge while no transfer is open raises `err_idle_ack` for one cycle. Its data changes neither `word_out` nor `line_out`.
- R10: `req_valid` during an open transfer is ignored, unless it arrives in the same cycle as that transfer's final acknowledge. In that case the new request is accepted back to back.
- R11: In any cycle without `rd_ack`, the read bus and word address have no effect on `word_out` or `line_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle start of a read transfer |
| req_line | input | 1 | 1 = eight-word line, 0 = single word |
| req_wide | input | 1 | 1 = 64-bit slave, 0 = 32-bit slave |
| req_be | input | 4 | Byte enables for a single-word read, bit k = byte k |
| rd_ack | input | 1 | Read acknowledge, one cycle per beat |
| rd_data | input | 64 | Read-data bus |
| rd_waddr | input | 3 | Word address of the current beat |
| line_out | output | 256 | Assembled line, word i at bits 32i+31:32i |
| word_out | output | 32 | Byte-masked single word |
| done | output | 1 | One-cycle completion pulse |
| err_idle_ack | output | 1 | One-cycle pulse for an acknowledge with no open transfer |

## Verification
The final acknowledge of one transfer and the request for the next one can fall in the same cycle. This cycle is also where the request path and the beat counter meet. The bench drives a new single-word request alongside the last beat of a single-word read, and then alongside the last beat of a wide line. It expects `done` for the first transfer, and then a second `done` after one more beat with no idle request cycle between them. It also sends a request in the middle of a narrow line and checks that the line still needs all eight beats.

// File: rtl/lfa_pkg.sv
package lfa_pkg;

  localparam int unsigned LFA_WORD_W = 32;
  localparam int unsigned LFA_BE_W   = LFA_WORD_W / 8;

  typedef enum logic {
    XF_IDLE = 1'b0,
    XF_OPEN = 1'b1
  } xfer_state_e;

  typedef struct packed {
    logic                is_line;
    logic                wide;
    logic [LFA_BE_W-1:0] be;
  } lfa_req_t;

endpackage

// File: rtl/lfa_beat_ctrl.sv
module lfa_beat_ctrl
  import lfa_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  lfa_req_t req_in,
  input  logic     rd_ack,
  output lfa_req_t cur_req,
  output logic     cap,
  output logic     done,
  output logic     err_idle
);

  localparam int unsigned CNT_W = $clog2(LINE_WORDS);
  localparam int unsigned TOT_W = CNT_W + 1;
  localparam logic [TOT_W-1:0] BEATS_NARROW = TOT_W'(LINE_WORDS);
  localparam logic [TOT_W-1:0] BEATS_WIDE   = TOT_W'(LINE_WORDS / 2);

  xfer_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  lfa_req_t         req_q, req_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [TOT_W-1:0] total;
  logic             last;
  logic             accept;

  always_comb begin
    if (!req_q.is_line)   total = TOT_W'(1);
    else if (req_q.wide)  total = BEATS_WIDE;
    else                  total = BEATS_NARROW;
  end

  assign cap    = rd_ack && (state_q == XF_OPEN);
  assign last   = cap && ({1'b0, cnt_q} == (total - TOT_W'(1)));
  assign accept = req_valid && ((state_q == XF_IDLE) || last);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    req_d   = req_q;
    if (cap) cnt_d = cnt_q + CNT_W'(1);
    if (last) state_d = XF_IDLE;
    if (accept) begin
      state_d = XF_OPEN;
      cnt_d   = '0;
      req_d   = req_in;
    end
    done_d = last;
    err_d  = rd_ack && (state_q == XF_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      cnt_q   <= '0;
      req_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      req_q   <= req_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign cur_req  = req_q;
  assign done     = done_q;
  assign err_idle = err_q;

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == XF_OPEN) |-> ({1'b0, cnt_q} < total));

  p_open_from_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == XF_OPEN) |-> (cnt_q == '0));

  p_done_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(rd_ack));

  p_err_not_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q));

  p_single_one_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == XF_OPEN) && !req_q.is_line) |-> (cnt_q == '0));

endmodule

// File: rtl/lfa_lane_sel.sv
module lfa_lane_sel
  import lfa_pkg::*;
#(
  parameter int unsigned WORD_W = LFA_WORD_W
) (
  input  logic [2*WORD_W-1:0] rd_data,
  input  logic                odd_word,
  input  logic [WORD_W/8-1:0] be,
  output logic [WORD_W-1:0]   hi_word,
  output logic [WORD_W-1:0]   lo_word,
  output logic [WORD_W-1:0]   masked_word
);

  localparam int unsigned NBYTES = WORD_W / 8;

  logic [WORD_W-1:0] picked;

  assign hi_word = rd_data[2*WORD_W-1:WORD_W];
  assign lo_word = rd_data[WORD_W-1:0];
  assign picked  = odd_word ? lo_word : hi_word;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign masked_word[8*k +: 8] = be[k] ? picked[8*k +: 8] : 8'h00;
  end

endmodule

// File: rtl/lfa_line_buf.sv
module lfa_line_buf
  import lfa_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned WORD_W     = LFA_WORD_W,
  parameter int unsigned AW         = $clog2(LINE_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wide,
  input  logic [AW-1:0]                waddr,
  input  logic [WORD_W-1:0]            hi_word,
  input  logic [WORD_W-1:0]            lo_word,
  output logic [LINE_WORDS*WORD_W-1:0] line_out
);

  logic [LINE_WORDS-1:0]          we;
  logic [LINE_WORDS*WORD_W-1:0]   line_q, line_d;

  for (genvar i = 0; i < LINE_WORDS; i++) begin : g_word
    localparam logic [AW-1:0] IDX = AW'(i);
    logic [WORD_W-1:0] src;

    assign we[i] = wr_en && (wide ? (waddr[AW-1:1] == IDX[AW-1:1])
                                  : (waddr == IDX));

    if (i % 2 == 0) begin : g_even
      assign src = hi_word;
    end else begin : g_odd
      assign src = lo_word;
    end

    assign line_d[i*WORD_W +: WORD_W] = we[i] ? src : line_q[i*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign line_out = line_q;

  p_narrow_one_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wide) |-> ($countones(we) == 1));

  p_wide_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wide) |-> ($countones(we) == 2 && we[{waddr[AW-1:1], 1'b0}]));

  p_line_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(line_q));

endmodule

// File: rtl/line_fill_asm.sv
module line_fill_asm
  import lfa_pkg::*;
#(
  parameter int unsigned LINE_WORDS = 8,
  parameter int unsigned WORD_W     = LFA_WORD_W,
  parameter int unsigned AW         = $clog2(LINE_WORDS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_line,
  input  logic                         req_wide,
  input  logic [WORD_W/8-1:0]          req_be,
  input  logic                         rd_ack,
  input  logic [2*WORD_W-1:0]          rd_data,
  input  logic [AW-1:0]                rd_waddr,
  output logic [LINE_WORDS*WORD_W-1:0] line_out,
  output logic [WORD_W-1:0]            word_out,
  output logic                         done,
  output logic                         err_idle_ack
);

  lfa_req_t          req_in, cur_req;
  logic              cap;
  logic [WORD_W-1:0] hi_word, lo_word, masked_word;
  logic [WORD_W-1:0] word_q, word_d;
  logic              line_we, word_we;

  assign req_in = '{is_line: req_line, wide: req_wide, be: req_be};

  lfa_beat_ctrl #(.LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_in   (req_in),
    .rd_ack   (rd_ack),
    .cur_req  (cur_req),
    .cap      (cap),
    .done     (done),
    .err_idle (err_idle_ack)
  );

  lfa_lane_sel #(.WORD_W(WORD_W)) u_lane (
    .rd_data    (rd_data),
    .odd_word   (rd_waddr[0]),
    .be         (cur_req.be),
    .hi_word    (hi_word),
    .lo_word    (lo_word),
    .masked_word(masked_word)
  );

  assign line_we = cap && cur_req.is_line;
  assign word_we = cap && !cur_req.is_line;

  lfa_line_buf #(.LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W), .AW(AW)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (line_we),
    .wide    (cur_req.wide),
    .waddr   (rd_waddr),
    .hi_word (hi_word),
    .lo_word (lo_word),
    .line_out(line_out)
  );

  always_comb begin
    word_d = word_q;
    if (word_we) word_d = masked_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_out = word_q;

  p_word_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ack |=> ($stable(word_out) && $stable(line_out)));

  p_idle_ack_harmless_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_idle_ack |-> ($stable(word_out) && $stable(line_out)));

endmodule

// File: tb/line_fill_asm_tb_top.sv
`timescale 1ns/1ps
module line_fill_asm_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_line, req_wide;
  logic [3:0]   req_be;
  logic         rd_ack;
  logic [63:0]  rd_data;
  logic [2:0]   rd_waddr;
  logic [255:0] line_out;
  logic [31:0]  word_out;
  logic         done, err_idle_ack;

  int errors = 0;
  int checks = 0;
  logic [255:0] exp_line;
  logic [31:0]  exp_word;

  always #2.5 clk = ~clk;

  line_fill_asm dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .req_wide(req_wide), .req_be(req_be), .rd_ack(rd_ack), .rd_data(rd_data),
    .rd_waddr(rd_waddr), .line_out(line_out), .word_out(word_out),
    .done(done), .err_idle_ack(err_idle_ack)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_be(input logic [31:0] w, input logic [3:0] be);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = w[8*k +: 8];
    return r;
  endfunction

  task automatic send_req(input logic line, input logic wide, input logic [3:0] be);
    @(negedge clk);
    req_valid = 1'b1; req_line = line; req_wide = wide; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic beat(input logic [63:0] d, input logic [2:0] a);
    @(negedge clk);
    rd_ack = 1'b1; rd_data = d; rd_waddr = a;
    @(negedge clk);
    rd_ack = 1'b0; rd_data = 64'hBAD0_BAD1_BAD2_BAD3; rd_waddr = ~a;
  endtask

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 done", {255'd0, done}, 256'd0);
    chk("R1 err", {255'd0, err_idle_ack}, 256'd0);
    chk("R1 word_out", {224'd0, word_out}, 256'd0);
    chk("R1 line_out", line_out, 256'd0);
  endtask

  task automatic t_single;
    send_req(1'b0, 1'b0, 4'hF);
    beat({32'h1111_2222, 32'h3333_4444}, 3'd5);
    chk("R3 narrow odd word", {224'd0, word_out}, {224'd0, 32'h3333_4444});
    chk("R8 done single", {255'd0, done}, 256'd1);
    chk("R3 line untouched", line_out, exp_line);
    gap(1);
    chk("R8 done one cycle", {255'd0, done}, 256'd0);
    send_req(1'b0, 1'b1, 4'b1010);
    gap(3);
    beat({32'hA1B2_C3D4, 32'h5566_7788}, 3'd2);
    exp_word = mask_be(32'hA1B2_C3D4, 4'b1010);
    chk("R4 masked even word", {224'd0, word_out}, {224'd0, exp_word});
    chk("R8 done after gap", {255'd0, done}, 256'd1);
  endtask

  task automatic t_narrow_line;
    logic [2:0] order [8] = '{3'd3, 3'd7, 3'd0, 3'd5, 3'd1, 3'd6, 3'd2, 3'd4};
    send_req(1'b1, 1'b0, 4'h0);
    for (int n = 0; n < 8; n++) begin
      logic [31:0] hi, lo;
      hi = 32'hA000_0000 | 32'(order[n]);
      lo = 32'h5000_0000 | 32'(order[n]);
      if (n == 3) begin
        req_valid = 1'b1; req_line = 1'b0; req_wide = 1'b0; req_be = 4'hF;
      end
      beat({hi, lo}, order[n]);
      req_valid = 1'b0;
      exp_line[32*order[n] +: 32] = order[n][0] ? lo : hi;
      if (n == 6) chk("R10 mid request ignored, no early done", {255'd0, done}, 256'd0);
      if (n < 7) gap(n % 3);
    end
    chk("R5 R7 narrow line", line_out, exp_line);
    chk("R5 done on eighth beat", {255'd0, done}, 256'd1);
    chk("R3 word untouched by line", {224'd0, word_out}, {224'd0, exp_word});
  endtask

  task automatic t_wide_line;
    logic [2:0] order [4] = '{3'd6, 3'd1, 3'd5, 3'd2};
    send_req(1'b1, 1'b1, 4'h0);
    for (int n = 0; n < 4; n++) begin
      logic [31:0] hi, lo;
      int base;
      hi = 32'hC000_0000 | (32'(n) << 4);
      lo = 32'h3000_0000 | (32'(n) << 4);
      beat({hi, lo}, order[n]);
      base = {order[n][2:1], 1'b0};
      exp_line[32*base +: 32]     = hi;
      exp_line[32*(base+1) +: 32] = lo;
      if (n == 2) chk("R6 no done after three wide beats", {255'd0, done}, 256'd0);
      gap(2);
    end
    chk("R6 R7 wide line", line_out, exp_line);
  endtask

  task automatic t_back_to_back;
    send_req(1'b0, 1'b0, 4'b0001);
    @(negedge clk);
    rd_ack = 1'b1; rd_data = {32'h0000_00AB, 32'h0000_00CD}; rd_waddr = 3'd0;
    req_valid = 1'b1; req_line = 1'b0; req_wide = 1'b1; req_be = 4'b1100;
    @(negedge clk);
    rd_ack = 1'b0; req_valid = 1'b0;
    chk("R10 first done", {255'd0, done}, 256'd1);
    chk("R4 first word", {224'd0, word_out}, 256'h0AB);
    beat({32'hFEDC_BA98, 32'h7654_3210}, 3'd1);
    chk("R10 second done", {255'd0, done}, 256'd1);
    chk("R10 second word", {224'd0, word_out}, {224'd0, 32'h7654_0000});
    exp_word = 32'h7654_0000;
    send_req(1'b1, 1'b1, 4'h0);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      rd_ack = 1'b1; rd_data = {32'h1000_0000 + 32'(n), 32'h2000_0000 + 32'(n)};
      rd_waddr = 3'(2 * n);
      if (n == 3) begin
        req_valid = 1'b1; req_line = 1'b0; req_wide = 1'b0; req_be = 4'hF;
      end
      exp_line[64*n +: 32]      = 32'h1000_0000 + 32'(n);
      exp_line[64*n + 32 +: 32] = 32'h2000_0000 + 32'(n);
      @(negedge clk);
      rd_ack = 1'b0; req_valid = 1'b0;
    end
    chk("R10 line done with request", {255'd0, done}, 256'd1);
    chk("R6 back-to-back line", line_out, exp_line);
    beat({32'h9999_0000, 32'h8888_0000}, 3'd4);
    exp_word = 32'h9999_0000;
    chk("R10 follow-on single accepted", {224'd0, word_out}, {224'd0, exp_word});
  endtask

  task automatic t_idle_ack;
    gap(2);
    beat({32'hDEAD_DEAD, 32'hBEEF_BEEF}, 3'd0);
    chk("R9 err pulse", {255'd0, err_idle_ack}, 256'd1);
    chk("R9 no done", {255'd0, done}, 256'd0);
    chk("R9 line unchanged", line_out, exp_line);
    chk("R9 word unchanged", {224'd0, word_out}, {224'd0, exp_word});
    gap(1);
    chk("R9 err one cycle", {255'd0, err_idle_ack}, 256'd0);
  endtask

  task automatic t_quiet_bus;
    send_req(1'b1, 1'b0, 4'h0);
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      rd_data = {2{32'(n) * 32'h0101_0101}}; rd_waddr = 3'(n);
    end
    @(negedge clk);
    chk("R11 line stable without ack", line_out, exp_line);
    chk("R11 word stable without ack", {224'd0, word_out}, {224'd0, exp_word});
    for (int n = 0; n < 8; n++) begin
      beat({32'h7700_0000 | 32'(n), 32'h6600_0000 | 32'(n)}, 3'(n));
      exp_line[32*n +: 32] = n[0] ? (32'h6600_0000 | 32'(n)) : (32'h7700_0000 | 32'(n));
    end
    chk("R5 sequential narrow line", line_out, exp_line);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_line = 1'b0; req_wide = 1'b0; req_be = '0;
    rd_ack = 1'b0; rd_data = '0; rd_waddr = '0;
    exp_line = '0; exp_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_narrow_line();
    t_wide_line();
    t_back_to_back();
    t_idle_ack();
    t_quiet_bus();
    gap(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule